// File: doc/BRIEF.md
# 8-bit Shift and Rotate Unit

This block is a purely combinational shifter for an 8-bit datapath. It takes a data operand, a full 8-bit distance operand and a 3-bit function code. It returns the shifted or rotated value together with a carry flag that holds the last bit pushed out.

An illegal function code raises an error flag. The surrounding calculator handles operand sequencing and opcode capture. It places the low three opcode bits of the shift group on `func_i`.

The three function bits are orthogonal controls:
- bit 0 requests an arithmetic (sign-filling) shift;
- bit 1 requests a rotate;
- bit 2 requests a leftward move.

Left operations reuse the right-moving datapath through bit reversal.

Top module: `shr_unit`

## Requirements
- R1: `func_i` encodes bit 0 = arithmetic, bit 1 = rotate, bit 2 = left. The legal codes are 3'b000 logical right, 3'b001 arithmetic right, 3'b010 rotate right, 3'b100 logical left and 3'b110 rotate left.
- R2: A logical right shift by n returns `data_i >> n` with zeros entering at bit 7.
- R3: An arithmetic right shift by n replicates `data_i[7]` into every vacated position.
- R4: A logical left shift by n returns `data_i << n` with zeros entering at bit 0.
- R5: Rotates move the value circularly by `amount_i` modulo 8, rightward for 3'b010 and leftward for 3'b110.
- R6: A shift with a distance of 8 or more yields all zeros for the logical shifts and all copies of `data_i[7]` for the arithmetic shift. A rotate by a nonzero multiple of 8 returns `data_i`.
- R7: For shifts, `carry_o` is the last bit moved out of the word. That is `data_i[n-1]` going right and `data_i[8-n]` going left for n in 1..8. It is 0 beyond 8, except for the arithmetic shift, where it equals `data_i[7]`. For rotates with a nonzero distance, `carry_o` is the last bit that wrapped: `result_o[7]` for rotate right and `result_o[0]` for rotate left.
- R8: A distance of zero returns `data_i` unchanged with `carry_o` = 0 for every legal code.
- R9: The codes 3'b011, 3'b101 and 3'b111 drive `error_o` = 1, `result_o` = 0 and `carry_o` = 0. Legal codes drive `error_o` = 0.
- R10: All outputs are a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Value to be shifted or rotated |
| amount_i | input | 8 | Shift or rotate distance |
| func_i | input | 3 | Function code (arithmetic, rotate, left bits) |
| result_o | output | 8 | Shifted or rotated value |
| carry_o | output | 1 | Last bit moved out of the word |
| error_o | output | 1 | Illegal function code |

## Verification
The embedded assertions cover several properties whenever the inputs settle:
- error handling on illegal codes, which forces zero outputs;
- pass-through at distance zero;
- saturation of the logical and arithmetic shifts at distance 8 and above;
- population count preserved by the rotator.

Exact bit placement, and the carry bit for each distance, can only be shown by the bench scenarios. The bench compares every output against an independent one-step-at-a-time model across sweeps of data patterns and distances. Those sweeps include the 7/8/9/255 boundary and wrap-around multiples of 8.

// File: rtl/shr_pkg.sv
`timescale 1ns/1ps
package shr_pkg;
  localparam int DATA_W = 8;
  localparam int DIST_W = 8;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_LSR = 3'b000,
    FN_ASR = 3'b001,
    FN_ROR = 3'b010,
    FN_LSL = 3'b100,
    FN_ROL = 3'b110
  } shr_fn_e;
endpackage

// File: rtl/shr_dist.sv
`timescale 1ns/1ps
// Distance conditioning: saturated shift count and modulo rotate count.
module shr_dist #(
  parameter int W  = 8,
  parameter int AW = 8,
  localparam int SW = $clog2(W + 2),
  localparam int LW = $clog2(W)
) (
  input  logic [AW-1:0] amount_i,
  output logic [SW-1:0] shift_cnt_o,
  output logic [LW-1:0] rot_cnt_o,
  output logic          zero_o
);
  localparam logic [SW-1:0] SAT = SW'(W + 1);

  always_comb begin
    if (amount_i > AW'(W)) shift_cnt_o = SAT;
    else                   shift_cnt_o = amount_i[SW-1:0];
  end

  assign rot_cnt_o = amount_i[LW-1:0];
  assign zero_o    = (amount_i == '0);

  always_comb begin
    AST_SAT_RANGE: assert (shift_cnt_o <= SAT) else $error("shift count above saturation"); // R6
  end
endmodule

// File: rtl/shr_barrel.sv
`timescale 1ns/1ps
// Logarithmic right shifter with programmable fill.
module shr_barrel #(
  parameter int N  = 9,
  parameter int SW = 4
) (
  input  logic [N-1:0]  vec_i,
  input  logic [SW-1:0] cnt_i,
  input  logic          fill_i,
  output logic [N-1:0]  vec_o
);
  logic [N-1:0] st [SW+1];
  assign st[0] = vec_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    if (SH >= N) begin : g_full
      assign st[s+1] = cnt_i[s] ? {N{fill_i}} : st[s];
    end else begin : g_part
      assign st[s+1] = cnt_i[s] ? {{SH{fill_i}}, st[s][N-1:SH]} : st[s];
    end
  end

  assign vec_o = st[SW];
endmodule

// File: rtl/shr_rotr.sv
`timescale 1ns/1ps
// Logarithmic right rotator, W must be a power of two.
module shr_rotr #(
  parameter int W  = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  input  logic [LW-1:0] cnt_i,
  output logic [W-1:0]  vec_o
);
  logic [W-1:0] st [LW+1];
  assign st[0] = vec_i;

  for (genvar s = 0; s < LW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign st[s+1] = cnt_i[s] ? {st[s][SH-1:0], st[s][W-1:SH]} : st[s];
  end

  assign vec_o = st[LW];

  always_comb begin
    AST_ROT_POPCOUNT: assert ($countones(vec_o) == $countones(vec_i)) else $error("rotate lost bits"); // R5
  end
endmodule

// File: rtl/shr_unit.sv
`timescale 1ns/1ps
module shr_unit
  import shr_pkg::*;
#(
  parameter int W  = shr_pkg::DATA_W,
  parameter int AW = shr_pkg::DIST_W
) (
  input  logic [W-1:0]      data_i,
  input  logic [AW-1:0]     amount_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [W-1:0]      result_o,
  output logic              carry_o,
  output logic              error_o
);
  localparam int SW = $clog2(W + 2);
  localparam int LW = $clog2(W);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic          legal, is_left, is_rot, is_arith;
  logic [SW-1:0] shift_cnt;
  logic [LW-1:0] rot_cnt;
  logic          dist_zero;
  logic [W-1:0]  oriented, rot_res, pre_res;
  logic [W:0]    sh_ext;
  logic          fill, pre_car;

  always_comb begin
    unique case (func_i)
      FN_LSR, FN_ASR, FN_ROR, FN_LSL, FN_ROL: legal = 1'b1;
      default:                                legal = 1'b0;
    endcase
  end

  assign is_arith = func_i[0];
  assign is_rot   = func_i[1];
  assign is_left  = func_i[2];

  shr_dist #(.W(W), .AW(AW)) u_dist (
    .amount_i   (amount_i),
    .shift_cnt_o(shift_cnt),
    .rot_cnt_o  (rot_cnt),
    .zero_o     (dist_zero)
  );

  // Left moves run through the right datapath on the mirrored word.
  assign oriented = is_left ? bit_rev(data_i) : data_i;
  assign fill     = is_arith & ~is_left & data_i[W-1];

  // Extra low bit catches the last bit shifted out.
  shr_barrel #(.N(W + 1), .SW(SW)) u_barrel (
    .vec_i (({oriented, 1'b0})),
    .cnt_i (shift_cnt),
    .fill_i(fill),
    .vec_o (sh_ext)
  );

  shr_rotr #(.W(W)) u_rot (
    .vec_i(oriented),
    .cnt_i(rot_cnt),
    .vec_o(rot_res)
  );

  assign pre_res = is_rot ? rot_res : sh_ext[W:1];
  assign pre_car = is_rot ? (~dist_zero & rot_res[W-1]) : sh_ext[0];

  assign result_o = legal ? (is_left ? bit_rev(pre_res) : pre_res) : '0;
  assign carry_o  = legal & pre_car;
  assign error_o  = ~legal;

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!error_o || (result_o == '0 && !carry_o)) else $error("illegal code leaked"); // R9
    AST_ZERO_DIST: assert (error_o || amount_i != '0 || (result_o == data_i && !carry_o)) else $error("zero distance altered data"); // R8
    AST_LOGIC_SAT: assert (!(func_i == FN_LSR || func_i == FN_LSL) || amount_i < AW'(W) || result_o == '0) else $error("logical shift not saturated"); // R6
    AST_ARITH_SAT: assert (func_i != FN_ASR || amount_i < AW'(W) || (result_o == {W{data_i[W-1]}} && carry_o == data_i[W-1])) else $error("arith shift not saturated"); // R6
    AST_LSR_TOPZERO: assert (func_i != FN_LSR || amount_i == '0 || !result_o[W-1]) else $error("logical right shift filled one"); // R2
  end
endmodule

// File: tb/shr_unit_test.sv
`timescale 1ns/1ps
module shr_unit_test;
  logic       clk = 1'b0;
  logic [7:0] data_i, amount_i;
  logic [2:0] func_i;
  logic [7:0] result_o;
  logic       carry_o, error_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shr_unit uut (
    .data_i  (data_i),
    .amount_i(amount_i),
    .func_i  (func_i),
    .result_o(result_o),
    .carry_o (carry_o),
    .error_o (error_o)
  );

  localparam logic [7:0] PATS [8] = '{8'h00, 8'h81, 8'hA5, 8'h7F, 8'hFF, 8'h01, 8'h80, 8'h3C};

  // Step-by-step reference model.
  function automatic void model(input logic [7:0] d, input logic [7:0] n, input logic [2:0] f,
                                output logic [7:0] r, output logic c, output logic e);
    r = d; c = 1'b0; e = 1'b0;
    case (f)
      3'b000: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[7:1]}; end
      3'b001: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[7], r[7:1]}; end
      3'b010: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[7:1]}; end
      3'b100: for (int i = 0; i < n; i++) begin c = r[7]; r = {r[6:0], 1'b0}; end
      3'b110: for (int i = 0; i < n; i++) begin c = r[7]; r = {r[6:0], r[7]}; end
      default: begin r = 8'h00; c = 1'b0; e = 1'b1; end
    endcase
  endfunction

  task automatic apply_chk(input string req, input logic [7:0] d, input logic [7:0] n, input logic [2:0] f);
    logic [7:0] er; logic ec, ee;
    @(posedge clk);
    data_i = d; amount_i = n; func_i = f;
    @(negedge clk);
    model(d, n, f, er, ec, ee);
    checks++;
    if (result_o !== er || carry_o !== ec || error_o !== ee) begin
      errors++;
      $display("FAIL %s: f=%b d=%h n=%0d got r=%h c=%b e=%b exp r=%h c=%b e=%b",
               req, f, d, n, result_o, carry_o, error_o, er, ec, ee);
    end
  endtask

  task automatic t_idle; // R10 R8: all-zero inputs
    apply_chk("R10", 8'h00, 8'h00, 3'b000);
  endtask

  task automatic t_lsr;
    for (int p = 0; p < 8; p++) for (int n = 1; n < 8; n++) apply_chk("R2", PATS[p], 8'(n), 3'b000);
  endtask

  task automatic t_asr;
    for (int p = 0; p < 8; p++) for (int n = 1; n < 8; n++) apply_chk("R3", PATS[p], 8'(n), 3'b001);
  endtask

  task automatic t_lsl;
    for (int p = 0; p < 8; p++) for (int n = 1; n < 8; n++) apply_chk("R4", PATS[p], 8'(n), 3'b100);
  endtask

  task automatic t_rot;
    for (int p = 0; p < 8; p++) for (int n = 1; n < 20; n++) begin
      apply_chk("R5", PATS[p], 8'(n), 3'b010);
      apply_chk("R5", PATS[p], 8'(n), 3'b110);
    end
  endtask

  task automatic t_bounds;
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 5; k++) begin
        logic [7:0] n;
        case (k) 0: n = 8'd8; 1: n = 8'd9; 2: n = 8'd16; 3: n = 8'd128; default: n = 8'd255; endcase
        apply_chk("R6", PATS[p], n, 3'b000);
        apply_chk("R6", PATS[p], n, 3'b001);
        apply_chk("R6", PATS[p], n, 3'b100);
        apply_chk("R6", PATS[p], n, 3'b010);
        apply_chk("R6", PATS[p], n, 3'b110);
      end
    end
  endtask

  task automatic t_carry; // R7: walking one to find which bit leaves
    for (int b = 0; b < 8; b++) for (int n = 1; n <= 9; n++) begin
      apply_chk("R7", 8'(1 << b), 8'(n), 3'b000);
      apply_chk("R7", 8'(1 << b), 8'(n), 3'b100);
      apply_chk("R7", 8'(1 << b), 8'(n), 3'b010);
      apply_chk("R7", 8'(1 << b), 8'(n), 3'b110);
    end
  endtask

  task automatic t_zero_dist;
    for (int p = 0; p < 8; p++) begin
      apply_chk("R8", PATS[p], 8'd0, 3'b000);
      apply_chk("R8", PATS[p], 8'd0, 3'b001);
      apply_chk("R8", PATS[p], 8'd0, 3'b010);
      apply_chk("R8", PATS[p], 8'd0, 3'b100);
      apply_chk("R8", PATS[p], 8'd0, 3'b110);
    end
  endtask

  task automatic t_illegal; // R9 and R1 decode
    for (int p = 0; p < 8; p++) begin
      apply_chk("R9", PATS[p], 8'd3, 3'b011);
      apply_chk("R9", PATS[p], 8'd1, 3'b101);
      apply_chk("R9", PATS[p], 8'd9, 3'b111);
    end
    for (int f = 0; f < 8; f++) apply_chk("R1", 8'hC9, 8'd2, 3'(f));
  endtask

  initial begin
    data_i = '0; amount_i = '0; func_i = '0;
    t_idle();
    t_lsr();
    t_asr();
    t_lsl();
    t_rot();
    t_bounds();
    t_carry();
    t_zero_dist();
    t_illegal();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: R10 run hung, got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule